// File: doc/BRIEF.md
# Byte-Lane DRAM Cycle Sequencer

This block drives a 16-bit asynchronous DRAM that is organised as two 8-bit lanes. Both lanes share the row strobe, the write enable and the multiplexed address. Each lane has its own column strobe. A host issues one request at a time over a ready/valid handshake. Each request carries a row/column address, a two-bit lane mask, a read/write flag and a write-timing choice of early or late. The sequencer expands the request into a row-strobe, column-strobe and write-enable waveform. All durations are counted in clock cycles set by parameters.

Because write enable is shared, both lanes of one cycle always use the same write timing. When a write's timing differs from that of the previous write, the sequencer adds a column-strobe precharge gap before the column strobes fall. A free-running timer requests a column-before-row refresh often enough that every one of the device's rows is visited within the retention period. A pending refresh takes priority over new host work at the next idle point. During refresh the device's internal row counter supplies the row, so the address bus is held at zero.

Top module: `lane_dram_seq`

## Requirements
- R1: Mask bit 0 selects the lower lane (data bits 7:0, lower column strobe) and mask bit 1 selects the upper lane (data bits 15:8, upper column strobe). Only the selected strobes go low during a host cycle, and mask 2'b11 is a word access.
- R2: A lane whose strobe stays high is not written, so its stored byte is unchanged. Its read data is don't-care.
- R3: When both lanes are selected, both column strobes fall in the same cycle and rise in the same cycle, so the two lanes never run in different modes.
- R4: For an early write, write enable is low for at least one cycle before the column strobes fall and stays low while they are low.
- R5: For a late write, write enable is high in the first column-strobe cycle and falls one cycle later, while the strobes are still low. Write enable never falls in the same cycle as a column strobe.
- R6: The first selected column strobe is low in the cycle T_RCD+1 clocks after the accepting edge. It is delayed by T_GAP further clocks when the request is a write whose early/late mode differs from the previous write. Reads never add the gap and never change the remembered mode.
- R7: A read returns rsp_valid as a single-cycle pulse, with the selected lanes of rsp_rdata equal to the stored bytes.
- R8: A refresh lowers both column strobes while the row strobe is high, then lowers the row strobe. Write enable stays high and the address is zero throughout.
- R9: Refresh starts once per REF_INT = CLK_HZ/1000*REF_MS/REF_ROWS cycles. Two refresh starts are never further apart than REF_INT plus the length of one host cycle.
- R10: While a refresh is pending or running, req_ready is low.
- R11: req_ready is high only when the device is idle, with all strobes high.
- R12: After reset, req_ready is 1, rsp_valid is 0, all strobes and write enable are high, and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | ROW_W+COL_W | Row (upper bits) and column (lower bits) |
| req_mask | input | 2 | Lane select: bit 0 lower, bit 1 upper |
| req_write | input | 1 | 1 = write, 0 = read |
| req_late | input | 1 | Write timing: 1 = late, 0 = early |
| req_wdata | input | 2*LANE_W | Write data |
| rsp_valid | output | 1 | Read data pulse |
| rsp_rdata | output | 2*LANE_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-lane column strobe, active low |
| dram_cash_n | output | 1 | Upper-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | 2*LANE_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 2*LANE_W | Data returned from the memory |

## Verification
The assertions assume that every accepted request has a non-zero lane mask and that T_CAS is at least two cycles, which gives a late write room to drop write enable inside the strobe window. The refresh-spacing property also assumes that a host cycle never stretches beyond its parameterised length. The stimulus always uses a non-zero mask and holds the request fields steady from the cycle valid is raised until acceptance. The memory model answers only while the row strobe is low and a lane strobe is active, so a value captured outside the strobe window would show up as a data mismatch.

// File: rtl/lds_pkg.sv
package lds_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_GAP,
    ST_SETUP,
    ST_CAS,
    ST_PRE,
    ST_RCAS,
    ST_RRAS
  } seq_state_t;

  typedef enum logic {
    WM_EARLY = 1'b0,
    WM_LATE  = 1'b1
  } wmode_t;

  localparam int NUM_LANES = 2;

endpackage

// File: rtl/lds_refresh_timer.sv
module lds_refresh_timer #(
  parameter int REF_INT = 781
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pending
);
  localparam int RT_W = $clog2(REF_INT + 1);

  logic [RT_W-1:0] tick_q;
  logic            tick;

  assign tick = (tick_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= RT_W'(REF_INT - 1);
      pending <= 1'b0;
    end else begin
      tick_q <= tick ? RT_W'(REF_INT - 1) : tick_q - 1'b1;
      if (tick)
        pending <= 1'b1;
      else if (take)
        pending <= 1'b0;
    end
  end

endmodule

// File: rtl/lds_mode_guard.sv
module lds_mode_guard
  import lds_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic is_write,
  input  logic is_late,
  output logic need_gap
);
  logic   seen_q;
  wmode_t last_q;
  wmode_t this_mode;

  assign this_mode = is_late ? WM_LATE : WM_EARLY;
  assign need_gap  = is_write && seen_q && (last_q != this_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      last_q <= WM_EARLY;
    end else if (accept && is_write) begin
      seen_q <= 1'b1;
      last_q <= this_mode;
    end
  end

endmodule

// File: rtl/lds_cycle_fsm.sv
module lds_cycle_fsm
  import lds_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int LANE_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_GAP  = 2,
  parameter int T_CAS  = 3,
  parameter int T_RP   = 2,
  parameter int T_CSR  = 1,
  parameter int T_RAS  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        go_req,
  input  logic                        go_ref,
  input  logic [ROW_W-1:0]            in_row,
  input  logic [COL_W-1:0]            in_col,
  input  logic [NUM_LANES-1:0]        in_mask,
  input  logic                        in_write,
  input  logic                        in_late,
  input  logic                        in_gap,
  input  logic [NUM_LANES*LANE_W-1:0] in_wdata,
  input  logic [NUM_LANES*LANE_W-1:0] dq_in,
  output logic                        idle,
  output logic                        ras_n,
  output logic [NUM_LANES-1:0]        cas_n,
  output logic                        we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  output logic [NUM_LANES*LANE_W-1:0] dq_out,
  output logic                        dq_oe,
  output logic                        rd_valid,
  output logic [NUM_LANES*LANE_W-1:0] rd_data
);
  localparam int DA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int DW    = NUM_LANES * LANE_W;
  localparam int MAXT  = (T_RCD > T_CAS ? T_RCD : T_CAS) + T_GAP + T_RP + T_CSR + T_RAS;
  localparam int CNT_W = $clog2(MAXT + 1) + 1;

  seq_state_t           st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [ROW_W-1:0]     row_q, row_d;
  logic [COL_W-1:0]     col_q, col_d;
  logic [NUM_LANES-1:0] mask_q, mask_d;
  logic                 write_q, write_d;
  logic                 late_q, late_d;
  logic                 gap_q, gap_d;
  logic [DW-1:0]        wdata_q, wdata_d;

  logic                 ras_n_d, we_n_d, dq_oe_d;
  logic [NUM_LANES-1:0] cas_n_d;
  logic [DA_W-1:0]      addr_d;
  logic                 cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // next-state and request capture
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    row_d   = row_q;
    col_d   = col_q;
    mask_d  = mask_q;
    write_d = write_q;
    late_d  = late_q;
    gap_d   = gap_q;
    wdata_d = wdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (go_ref) begin
          st_d  = ST_RCAS;
          cnt_d = CNT_W'(T_CSR - 1);
        end else if (go_req) begin
          st_d    = ST_ROW;
          cnt_d   = CNT_W'(T_RCD - 1);
          row_d   = in_row;
          col_d   = in_col;
          mask_d  = in_mask;
          write_d = in_write;
          late_d  = in_late;
          gap_d   = in_gap;
          wdata_d = in_wdata;
        end
      end
      ST_ROW: begin
        if (cnt_zero) begin
          if (gap_q) begin
            st_d  = ST_GAP;
            cnt_d = CNT_W'(T_GAP - 1);
          end else begin
            st_d  = ST_SETUP;
            cnt_d = '0;
          end
        end
      end
      ST_GAP: begin
        if (cnt_zero) begin
          st_d  = ST_SETUP;
          cnt_d = '0;
        end
      end
      ST_SETUP: begin
        st_d  = ST_CAS;
        cnt_d = CNT_W'(T_CAS - 1);
      end
      ST_CAS: begin
        if (cnt_zero) begin
          st_d  = ST_PRE;
          cnt_d = CNT_W'(T_RP - 1);
        end
      end
      ST_PRE: begin
        if (cnt_zero) st_d = ST_IDLE;
      end
      ST_RCAS: begin
        if (cnt_zero) begin
          st_d  = ST_RRAS;
          cnt_d = CNT_W'(T_RAS - 1);
        end
      end
      ST_RRAS: begin
        if (cnt_zero) begin
          st_d  = ST_PRE;
          cnt_d = CNT_W'(T_RP - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // output decode from the next state, registered below
  always_comb begin
    ras_n_d = 1'b1;
    cas_n_d = '1;
    we_n_d  = 1'b1;
    dq_oe_d = 1'b0;
    addr_d  = '0;
    unique case (st_d)
      ST_ROW: begin
        ras_n_d = 1'b0;
        addr_d  = DA_W'(row_d);
      end
      ST_GAP: begin
        ras_n_d = 1'b0;
        addr_d  = DA_W'(col_d);
      end
      ST_SETUP: begin
        ras_n_d = 1'b0;
        addr_d  = DA_W'(col_d);
        we_n_d  = !(write_d && !late_d);
        dq_oe_d = write_d;
      end
      ST_CAS: begin
        ras_n_d = 1'b0;
        addr_d  = DA_W'(col_d);
        for (int l = 0; l < NUM_LANES; l++)
          cas_n_d[l] = !mask_d[l];
        we_n_d  = !(write_d && (!late_d || (cnt_d != CNT_W'(T_CAS - 1))));
        dq_oe_d = write_d;
      end
      ST_RCAS: cas_n_d = '0;
      ST_RRAS: begin
        cas_n_d = '0;
        ras_n_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      row_q    <= '0;
      col_q    <= '0;
      mask_q   <= '0;
      write_q  <= 1'b0;
      late_q   <= 1'b0;
      gap_q    <= 1'b0;
      wdata_q  <= '0;
      ras_n    <= 1'b1;
      cas_n    <= '1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      addr     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      row_q    <= row_d;
      col_q    <= col_d;
      mask_q   <= mask_d;
      write_q  <= write_d;
      late_q   <= late_d;
      gap_q    <= gap_d;
      wdata_q  <= wdata_d;
      ras_n    <= ras_n_d;
      cas_n    <= cas_n_d;
      we_n     <= we_n_d;
      dq_oe    <= dq_oe_d;
      addr     <= addr_d;
      rd_valid <= (st_q == ST_CAS) && cnt_zero && !write_q;
      if ((st_q == ST_CAS) && cnt_zero && !write_q)
        rd_data <= dq_in;
    end
  end

  assign idle   = (st_q == ST_IDLE);
  assign dq_out = wdata_q;

endmodule

// File: rtl/lane_dram_seq.sv
module lane_dram_seq
  import lds_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int COL_W    = 10,
  parameter int LANE_W   = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int REF_MS   = 16,
  parameter int REF_ROWS = 1024,
  parameter int T_RCD    = 2,
  parameter int T_GAP    = 2,
  parameter int T_CAS    = 3,
  parameter int T_RP     = 2,
  parameter int T_CSR    = 1,
  parameter int T_RAS    = 3
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         req_valid,
  output logic                                         req_ready,
  input  logic [ROW_W+COL_W-1:0]                       req_addr,
  input  logic [1:0]                                   req_mask,
  input  logic                                         req_write,
  input  logic                                         req_late,
  input  logic [2*LANE_W-1:0]                          req_wdata,
  output logic                                         rsp_valid,
  output logic [2*LANE_W-1:0]                          rsp_rdata,
  output logic                                         dram_ras_n,
  output logic                                         dram_casl_n,
  output logic                                         dram_cash_n,
  output logic                                         dram_we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [2*LANE_W-1:0]                          dram_dq_out,
  output logic                                         dram_dq_oe,
  input  logic [2*LANE_W-1:0]                          dram_dq_in
);
  localparam int REF_INT = CLK_HZ / 1000 * REF_MS / REF_ROWS;

  logic                 ref_pend, fsm_idle, accept, go_ref, need_gap;
  logic [NUM_LANES-1:0] cas_n;

  assign req_ready = fsm_idle && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign go_ref    = fsm_idle && ref_pend;

  lds_refresh_timer #(.REF_INT(REF_INT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .take    (go_ref),
    .pending (ref_pend)
  );

  lds_mode_guard u_guard (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .is_write (req_write),
    .is_late  (req_late),
    .need_gap (need_gap)
  );

  lds_cycle_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W),
    .T_RCD(T_RCD), .T_GAP(T_GAP), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .go_req   (accept),
    .go_ref   (go_ref),
    .in_row   (req_addr[ROW_W+COL_W-1:COL_W]),
    .in_col   (req_addr[COL_W-1:0]),
    .in_mask  (req_mask),
    .in_write (req_write),
    .in_late  (req_late),
    .in_gap   (need_gap),
    .in_wdata (req_wdata),
    .dq_in    (dram_dq_in),
    .idle     (fsm_idle),
    .ras_n    (dram_ras_n),
    .cas_n    (cas_n),
    .we_n     (dram_we_n),
    .addr     (dram_addr),
    .dq_out   (dram_dq_out),
    .dq_oe    (dram_dq_oe),
    .rd_valid (rsp_valid),
    .rd_data  (rsp_rdata)
  );

  assign dram_casl_n = cas_n[0];
  assign dram_cash_n = cas_n[1];

endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
  parameter int DA_W    = 10,
  parameter int REF_INT = 781,
  parameter int SLACK   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            ras_n,
  input logic            casl_n,
  input logic            cash_n,
  input logic            we_n,
  input logic [DA_W-1:0] addr,
  input logic            req_ready,
  input logic            rsp_valid
);
  localparam int LIMIT = REF_INT + SLACK;
  localparam int GC_W  = $clog2(LIMIT + 2) + 1;

  logic [GC_W-1:0] gap_cnt;
  logic            casl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt   <= '0;
      casl_prev <= 1'b1;
    end else begin
      casl_prev <= casl_n;
      if (casl_prev && !casl_n && ras_n)
        gap_cnt <= '0;
      else if (gap_cnt != '1)
        gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_lanes_low_together_R3: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $fell(casl_n) && !cash_n) |-> $fell(cash_n));

  assert_lanes_high_together_R3: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $rose(casl_n) && cash_n) |-> $rose(cash_n));

  assert_we_apart_from_cas_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (!$fell(casl_n) && !$fell(cash_n)));

  assert_cbr_order_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !casl_n) |-> ($past(!casl_n) && $past(!cash_n) && we_n && (addr == '0)));

  assert_ready_only_idle_R11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ras_n && casl_n && cash_n && we_n));

  assert_rsp_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_refresh_spacing_R9: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= GC_W'(LIMIT));

endmodule

bind lane_dram_seq lds_checker #(
  .DA_W    ((ROW_W > COL_W) ? ROW_W : COL_W),
  .REF_INT (REF_INT),
  .SLACK   (T_RCD + T_GAP + T_CAS + T_RP + T_CSR + T_RAS + T_RP + 6)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (dram_ras_n),
  .casl_n    (dram_casl_n),
  .cash_n    (dram_cash_n),
  .we_n      (dram_we_n),
  .addr      (dram_addr),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/lane_dram_seq_tb.sv
module lane_dram_seq_tb;
  localparam int ROW_W = 10, COL_W = 10, LANE_W = 8;
  localparam int CLK_HZ = 50_000_000, REF_MS = 16, REF_ROWS = 1024;
  localparam int T_RCD = 2, T_GAP = 2, T_CAS = 3, T_RP = 2, T_CSR = 1, T_RAS = 3;
  localparam int REF_INT = CLK_HZ / 1000 * REF_MS / REF_ROWS;
  localparam int AW = ROW_W + COL_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_mask = '0;
  logic req_write = 1'b0, req_late = 1'b0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid;
  logic [15:0] rsp_rdata;
  logic dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_dq_oe;
  logic [9:0] dram_addr;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in = '0;

  int checks = 0, fails = 0, ref_count = 0;
  logic [15:0] ref_mem [int];
  logic [15:0] dev_mem [int];
  logic [17:0] exp_q [$];
  logic have_mode = 1'b0, last_late = 1'b0;

  always #10 clk = ~clk;

  lane_dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W), .CLK_HZ(CLK_HZ),
    .REF_MS(REF_MS), .REF_ROWS(REF_ROWS), .T_RCD(T_RCD), .T_GAP(T_GAP),
    .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_write(req_write),
    .req_late(req_late), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n),
    .dram_cash_n(dram_cash_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_mem(ref logic [15:0] m [int], input int k);
    return m.exists(k) ? m[k] : 16'h0000;
  endfunction

  // memory model: row on row-strobe fall, column on column-strobe fall
  logic m_ras_p = 1'b1, m_cas_p = 1'b1;
  logic [9:0] m_row = '0, m_col = '0;
  always @(negedge clk) begin
    logic [15:0] w;
    int key;
    if (!dram_ras_n && m_ras_p && dram_casl_n && dram_cash_n) m_row = dram_addr;
    if (!dram_ras_n && m_cas_p && !(dram_casl_n && dram_cash_n)) m_col = dram_addr;
    key = int'({m_row, m_col});
    if (!dram_ras_n && !dram_we_n && dram_dq_oe) begin
      w = rd_mem(dev_mem, key);
      if (!dram_casl_n) w[7:0]  = dram_dq_out[7:0];
      if (!dram_cash_n) w[15:8] = dram_dq_out[15:8];
      dev_mem[key] = w;
    end
    dram_dq_in = (!dram_ras_n && !(dram_casl_n && dram_cash_n)) ? rd_mem(dev_mem, key) : 16'hdead;
    m_ras_p = dram_ras_n;
    m_cas_p = dram_casl_n && dram_cash_n;
  end

  // refresh monitor (R8, R10)
  logic r_cas_p = 1'b1;
  always @(negedge clk) begin
    if (!rst && dram_ras_n && !dram_casl_n && !dram_cash_n && r_cas_p) begin
      ref_count++;
      check(dram_we_n == 1'b1 && dram_addr == '0, "R8 refresh we/addr", {dram_we_n, dram_addr}, {1'b1, 10'h0});
      check(req_ready == 1'b0, "R10 ready low in refresh", req_ready, 0);
    end
    r_cas_p = dram_casl_n && dram_cash_n;
  end

  // scoreboard monitor (R7, R2)
  always @(negedge clk) begin
    logic [17:0] e;
    logic [15:0] m;
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected rsp", 1, 0);
      else begin
        e = exp_q.pop_front();
        m = {{8{e[17]}}, {8{e[16]}}};
        check((rsp_rdata & m) == (e[15:0] & m), "R7/R2 read data", rsp_rdata & m, e[15:0] & m);
      end
    end
  end

  task automatic do_req(input logic [AW-1:0] a, input logic [1:0] mk, input logic w,
                        input logic lt, input logic [15:0] d);
    int k;
    logic gap, prev_we;
    logic [15:0] v;
    gap = w && have_mode && (last_late != lt);
    if (w) begin have_mode = 1'b1; last_late = lt; end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_mask = mk; req_write = w; req_late = lt; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    prev_we = dram_we_n;
    while (!(!dram_ras_n && !(dram_casl_n && dram_cash_n)) && k < 100) begin
      prev_we = dram_we_n;
      @(negedge clk);
      k++;
    end
    check(k == T_RCD + 2 + (gap ? T_GAP : 0), "R6 strobe latency", k, T_RCD + 2 + (gap ? T_GAP : 0));
    check({dram_cash_n, dram_casl_n} == ~mk, "R1/R3 lane strobes", {dram_cash_n, dram_casl_n}, ~mk);
    if (w && !lt)
      check(dram_we_n == 1'b0 && prev_we == 1'b0, "R4 early we", {prev_we, dram_we_n}, 0);
    else if (w && lt) begin
      check(dram_we_n == 1'b1, "R5 late we high first", dram_we_n, 1);
      @(negedge clk);
      check(dram_we_n == 1'b0 && {dram_cash_n, dram_casl_n} == ~mk, "R5 late we falls in strobe",
            {dram_we_n, dram_cash_n, dram_casl_n}, {1'b0, ~mk});
    end else
      check(dram_we_n == 1'b1, "R7 read we high", dram_we_n, 1);
    if (w) begin
      v = rd_mem(ref_mem, int'(a));
      if (mk[0]) v[7:0]  = d[7:0];
      if (mk[1]) v[15:8] = d[15:8];
      ref_mem[int'(a)] = v;
    end else
      exp_q.push_back({mk, rd_mem(ref_mem, int'(a))});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R12 reset handshake", {req_ready, rsp_valid}, 2'b10);
    check({dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_dq_oe} == 5'b11110,
          "R12 reset strobes", {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_dq_oe}, 5'b11110);
    do_req(20'h00010, 2'b11, 1, 0, 16'h1234);
    do_req(20'h00010, 2'b01, 1, 1, 16'h99ab);
    do_req(20'h00010, 2'b11, 0, 0, 16'h0);
    do_req(20'h21003, 2'b11, 1, 1, 16'hcdef);
    do_req(20'h21003, 2'b10, 1, 0, 16'h7711);
    do_req(20'h21003, 2'b01, 0, 0, 16'h0);
    do_req(20'h21003, 2'b10, 0, 1, 16'h0);
    do_req(20'h21003, 2'b11, 0, 0, 16'h0);
    do_req(20'hfffff, 2'b11, 1, 0, 16'h0f0f);
    do_req(20'hfffff, 2'b11, 0, 0, 16'h0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);
    ref_count = 0;
    repeat (4 * REF_INT) @(negedge clk);
    check(ref_count >= 4 && ref_count <= 5, "R9 refresh rate", ref_count, 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule